// File: doc/BRIEF.md
# Two-Slot Trace Cache Fetch Unit

This block supplies two instructions per fetch from a small direct-mapped trace cache that sits in front of a plain instruction memory. A trace line holds two instructions in the order in which they actually executed. When the first of the two is a taken branch, the second slot holds the branch target rather than the next sequential word. Each line is keyed by its starting PC and by the direction of the branch it contains. Lines without a branch match on PC alone.

Every fetch probes the trace cache first, using the fetch PC and the predicted direction from an external predictor. On a hit the stored bundle is returned. On a miss the two sequential words at PC and PC+1 are read from the backing instruction memory. The retire side builds trace lines through a fill port, which supplies the start PC, the branch information, both instructions and the branch target. The backing memory has its own write port for loading program words.

All results are registered and appear in the cycle after the fetch request. The next-fetch PC follows a taken trace to the word after the target. In every other case it advances by two.

Top module: `trace_fetch_unit`

## Requirements
- R1: Synchronous active-low reset sets `out_valid` to 0 and invalidates every trace line, so the first fetch to any PC after reset misses.
- R2: `out_valid` is high in the cycle after a cycle with `fetch_valid` high, and low in the cycle after a cycle with `fetch_valid` low.
- R3: On a miss, `out_hit` is 0, `out_inst0` is memory word PC, `out_inst1` is memory word (PC+1) mod 2^PC_W, and `out_next_pc` is (PC+2) mod 2^PC_W.
- R4: A fill writes the line at index PC[TC_IDX_W-1:0] with tag PC[PC_W-1:TC_IDX_W] and marks it valid. A later fetch with the same PC and a matching direction hits and returns the stored `fill_inst0` and `fill_inst1`.
- R5: A line filled with `fill_has_branch`=1 misses when `fetch_pred_taken` differs from its stored `fill_taken`, and the backing memory then supplies the bundle.
- R6: A line filled with `fill_has_branch`=0 hits for either value of `fetch_pred_taken`.
- R7: On a hit to a line with a taken branch, `out_next_pc` is `fill_target`+1. On a hit to a not-taken or branch-free line, it is PC+2.
- R8: A fetch whose index matches a valid line but whose tag bits differ misses.
- R9: A fill to an occupied index replaces the earlier line, so the earlier PC then misses.
- R10: A fetch in the same cycle as a fill to the same index sees the line contents from before that fill.
- R11: A memory write stores the word for later misses. A trace hit returns the trace contents even when the memory word at that PC has since changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Fetch request this cycle |
| fetch_pc | input | PC_W | Fetch PC (one unit per instruction) |
| fetch_pred_taken | input | 1 | Predicted direction used in the lookup |
| fill_valid | input | 1 | Write a trace line this cycle |
| fill_pc | input | PC_W | Start PC of the line being written |
| fill_has_branch | input | 1 | First slot is a branch (1) or the line is branch-free (0) |
| fill_taken | input | 1 | Resolved branch direction, 1 = taken |
| fill_inst0 | input | INST_W | First instruction in execution order |
| fill_inst1 | input | INST_W | Second instruction in execution order |
| fill_target | input | PC_W | Branch target PC, used when taken |
| mem_wr_en | input | 1 | Write one backing memory word |
| mem_wr_addr | input | PC_W | Backing memory write address |
| mem_wr_data | input | INST_W | Backing memory write data |
| out_valid | output | 1 | Bundle below belongs to last cycle's fetch |
| out_hit | output | 1 | Bundle came from the trace cache |
| out_inst0 | output | INST_W | First instruction of the bundle |
| out_inst1 | output | INST_W | Second instruction of the bundle |
| out_next_pc | output | PC_W | PC for the following fetch |

## Verification
Directed sequences cover the cases in which the key must separate lines. The same PC is fetched with both predicted directions, branch-free lines are fetched with both directions, two PCs alias to one index, and a fill lands on the index being fetched in the same cycle. These cases separate a correct direction compare from one that ignores the branch-free mark or the direction. They also separate a tag compare from an index-only compare, and read-before-write from write-through. A constrained random phase mixes fills and fetches over a 32-word PC range, so hits, direction misses and aliasing evictions interleave. Fetches at the top of the address space check the wrap of PC+1 and PC+2.

// File: rtl/tc_pkg.sv
// Shared types for the trace cache fetch unit.
// Assumes: one PC unit per instruction, two instruction slots per line.
package tc_pkg;

    // Branch information kept beside each trace line
    typedef struct packed {
        logic has_br;   // first slot is a branch
        logic taken;    // resolved direction of that branch
    } tc_dir_t;

    // Where a fetch bundle was taken from
    typedef enum logic {
        SRC_MEM   = 1'b0,
        SRC_TRACE = 1'b1
    } tc_src_e;

endpackage

// File: rtl/tc_backing_mem.sv
// Backing instruction memory: one write port, two combinational read ports
// returning words at rd_addr and rd_addr+1 (wrapping). Not reset; the
// contents are loaded through the write port before use.
module tc_backing_mem #(
    parameter int PC_W   = 8,
    parameter int INST_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PC_W-1:0]   wr_addr,
    input  logic [INST_W-1:0] wr_data,
    input  logic [PC_W-1:0]   rd_addr,
    output logic [INST_W-1:0] rd_word0,
    output logic [INST_W-1:0] rd_word1
);
    localparam int DEPTH = 1 << PC_W;

    logic [INST_W-1:0] mem_q [DEPTH];
    logic [PC_W-1:0]   rd_addr_nxt;

    // Store one word per write request
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Read the sequential pair starting at the fetch address
    always_comb begin
        rd_addr_nxt = rd_addr + PC_W'(1);
        rd_word0    = mem_q[rd_addr];
        rd_word1    = mem_q[rd_addr_nxt];
    end

    // R11
    property mem_write_lands_p;
        @(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(wr_addr)] == $past(wr_data));
    endproperty
    mem_write_lands_chk: assert property (mem_write_lands_p);

endmodule

// File: rtl/tc_line_store.sv
// Direct-mapped trace line store. Lookup is combinational on the current
// array state, so a fill in the same cycle becomes visible only from the
// next cycle. Only valid bits are reset; data fields are written on fill.
module tc_line_store
    import tc_pkg::*;
#(
    parameter int PC_W     = 8,
    parameter int TC_IDX_W = 3,
    parameter int INST_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   rd_pc,
    input  logic              rd_taken,
    input  logic              wr_en,
    input  logic [PC_W-1:0]   wr_pc,
    input  tc_dir_t           wr_dir,
    input  logic [INST_W-1:0] wr_inst0,
    input  logic [INST_W-1:0] wr_inst1,
    input  logic [PC_W-1:0]   wr_target,
    output logic              hit,
    output logic              hit_redirect,
    output logic [INST_W-1:0] hit_inst0,
    output logic [INST_W-1:0] hit_inst1,
    output logic [PC_W-1:0]   hit_target
);
    localparam int LINES = 1 << TC_IDX_W;
    localparam int TAG_W = PC_W - TC_IDX_W;

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q    [LINES];
    tc_dir_t           dir_q    [LINES];
    logic [INST_W-1:0] inst0_q  [LINES];
    logic [INST_W-1:0] inst1_q  [LINES];
    logic [PC_W-1:0]   target_q [LINES];

    logic [TC_IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0]    rd_tag, wr_tag;
    logic                tag_eq, dir_ok;

    assign rd_idx = rd_pc[TC_IDX_W-1:0];
    assign rd_tag = rd_pc[PC_W-1:TC_IDX_W];
    assign wr_idx = wr_pc[TC_IDX_W-1:0];
    assign wr_tag = wr_pc[PC_W-1:TC_IDX_W];

    // Valid bits: cleared on reset, set by a fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Line payload: tag, branch info, instructions and target
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]    <= wr_tag;
            dir_q[wr_idx]    <= wr_dir;
            inst0_q[wr_idx]  <= wr_inst0;
            inst1_q[wr_idx]  <= wr_inst1;
            target_q[wr_idx] <= wr_target;
        end
    end

    // Match on tag, and on direction unless the line is branch-free
    always_comb begin
        tag_eq       = (tag_q[rd_idx] == rd_tag);
        dir_ok       = !dir_q[rd_idx].has_br || (dir_q[rd_idx].taken == rd_taken);
        hit          = valid_q[rd_idx] && tag_eq && dir_ok;
        hit_redirect = dir_q[rd_idx].has_br && dir_q[rd_idx].taken;
        hit_inst0    = inst0_q[rd_idx];
        hit_inst1    = inst1_q[rd_idx];
        hit_target   = target_q[rd_idx];
    end

    // R4
    property fill_sets_valid_p;
        @(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)];
    endproperty
    fill_sets_valid_chk: assert property (fill_sets_valid_p);

endmodule

// File: rtl/trace_fetch_unit.sv
// Trace cache fetch unit. Probes the trace line store with the fetch PC and
// predicted direction; on a miss takes the sequential pair from the backing
// memory. The bundle, hit flag and next-fetch PC are registered, so they
// appear one cycle after the request.
module trace_fetch_unit
    import tc_pkg::*;
#(
    parameter int PC_W     = 8,
    parameter int TC_IDX_W = 3,
    parameter int INST_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [PC_W-1:0]   fetch_pc,
    input  logic              fetch_pred_taken,
    input  logic              fill_valid,
    input  logic [PC_W-1:0]   fill_pc,
    input  logic              fill_has_branch,
    input  logic              fill_taken,
    input  logic [INST_W-1:0] fill_inst0,
    input  logic [INST_W-1:0] fill_inst1,
    input  logic [PC_W-1:0]   fill_target,
    input  logic              mem_wr_en,
    input  logic [PC_W-1:0]   mem_wr_addr,
    input  logic [INST_W-1:0] mem_wr_data,
    output logic              out_valid,
    output logic              out_hit,
    output logic [INST_W-1:0] out_inst0,
    output logic [INST_W-1:0] out_inst1,
    output logic [PC_W-1:0]   out_next_pc
);
    tc_dir_t           fill_dir;
    logic              tc_hit, tc_redirect;
    logic [INST_W-1:0] tc_inst0, tc_inst1, mem_word0, mem_word1;
    logic [PC_W-1:0]   tc_target;
    tc_src_e           src;
    logic [INST_W-1:0] sel_inst0, sel_inst1;
    logic [PC_W-1:0]   sel_next_pc;

    assign fill_dir = '{has_br: fill_has_branch, taken: fill_taken};

    tc_line_store #(
        .PC_W     (PC_W),
        .TC_IDX_W (TC_IDX_W),
        .INST_W   (INST_W)
    ) u_lines (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_pc        (fetch_pc),
        .rd_taken     (fetch_pred_taken),
        .wr_en        (fill_valid),
        .wr_pc        (fill_pc),
        .wr_dir       (fill_dir),
        .wr_inst0     (fill_inst0),
        .wr_inst1     (fill_inst1),
        .wr_target    (fill_target),
        .hit          (tc_hit),
        .hit_redirect (tc_redirect),
        .hit_inst0    (tc_inst0),
        .hit_inst1    (tc_inst1),
        .hit_target   (tc_target)
    );

    tc_backing_mem #(
        .PC_W   (PC_W),
        .INST_W (INST_W)
    ) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mem_wr_en),
        .wr_addr  (mem_wr_addr),
        .wr_data  (mem_wr_data),
        .rd_addr  (fetch_pc),
        .rd_word0 (mem_word0),
        .rd_word1 (mem_word1)
    );

    // Pick the bundle source and the successor PC
    always_comb begin
        src         = tc_hit ? SRC_TRACE : SRC_MEM;
        sel_inst0   = (src == SRC_TRACE) ? tc_inst0 : mem_word0;
        sel_inst1   = (src == SRC_TRACE) ? tc_inst1 : mem_word1;
        sel_next_pc = ((src == SRC_TRACE) && tc_redirect) ? tc_target + PC_W'(1)
                                                          : fetch_pc + PC_W'(2);
    end

    // Output valid follows the request with one cycle of latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
        end else begin
            out_valid <= fetch_valid;
            if (fetch_valid) begin
                out_hit <= (src == SRC_TRACE);
            end
        end
    end

    // Bundle registers load only on a fetch
    always_ff @(posedge clk) begin
        if (fetch_valid) begin
            out_inst0   <= sel_inst0;
            out_inst1   <= sel_inst1;
            out_next_pc <= sel_next_pc;
        end
    end

    // R2
    property valid_follows_fetch_p;
        @(posedge clk) disable iff (!rst_n)
        fetch_valid |=> out_valid;
    endproperty
    valid_follows_fetch_chk: assert property (valid_follows_fetch_p);

    // R2
    property idle_gives_no_valid_p;
        @(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> !out_valid;
    endproperty
    idle_gives_no_valid_chk: assert property (idle_gives_no_valid_p);

    // R4
    property hit_flag_from_store_p;
        @(posedge clk) disable iff (!rst_n)
        fetch_valid |=> (out_hit == $past(tc_hit));
    endproperty
    hit_flag_from_store_chk: assert property (hit_flag_from_store_p);

    // R3
    property seq_next_pc_p;
        @(posedge clk) disable iff (!rst_n)
        (fetch_valid && !(tc_hit && tc_redirect)) |=>
            (out_next_pc == $past(fetch_pc) + PC_W'(2));
    endproperty
    seq_next_pc_chk: assert property (seq_next_pc_p);

    // R7
    property redirect_next_pc_p;
        @(posedge clk) disable iff (!rst_n)
        (fetch_valid && tc_hit && tc_redirect) |=>
            (out_next_pc == $past(tc_target) + PC_W'(1));
    endproperty
    redirect_next_pc_chk: assert property (redirect_next_pc_p);

endmodule

// File: tb/sim_trace_fetch_unit.sv
module sim_trace_fetch_unit;
    localparam int PC_W     = 8;
    localparam int TC_IDX_W = 3;
    localparam int INST_W   = 32;
    localparam int LINES    = 1 << TC_IDX_W;
    localparam int DEPTH    = 1 << PC_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fetch_valid = 1'b0;
    logic [PC_W-1:0]   fetch_pc = '0;
    logic              fetch_pred_taken = 1'b0;
    logic              fill_valid = 1'b0;
    logic [PC_W-1:0]   fill_pc = '0;
    logic              fill_has_branch = 1'b0;
    logic              fill_taken = 1'b0;
    logic [INST_W-1:0] fill_inst0 = '0;
    logic [INST_W-1:0] fill_inst1 = '0;
    logic [PC_W-1:0]   fill_target = '0;
    logic              mem_wr_en = 1'b0;
    logic [PC_W-1:0]   mem_wr_addr = '0;
    logic [INST_W-1:0] mem_wr_data = '0;
    logic              out_valid, out_hit;
    logic [INST_W-1:0] out_inst0, out_inst1;
    logic [PC_W-1:0]   out_next_pc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    logic [INST_W-1:0] ref_mem [DEPTH];
    bit                ref_v   [LINES];
    logic [PC_W-1:0]   ref_pc  [LINES];
    bit                ref_br  [LINES];
    bit                ref_tk  [LINES];
    logic [INST_W-1:0] ref_i0  [LINES];
    logic [INST_W-1:0] ref_i1  [LINES];
    logic [PC_W-1:0]   ref_tgt [LINES];

    always #2 clk = ~clk;

    trace_fetch_unit #(.PC_W(PC_W), .TC_IDX_W(TC_IDX_W), .INST_W(INST_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .fetch_pred_taken(fetch_pred_taken),
        .fill_valid(fill_valid), .fill_pc(fill_pc), .fill_has_branch(fill_has_branch),
        .fill_taken(fill_taken), .fill_inst0(fill_inst0), .fill_inst1(fill_inst1),
        .fill_target(fill_target),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .out_valid(out_valid), .out_hit(out_hit), .out_inst0(out_inst0),
        .out_inst1(out_inst1), .out_next_pc(out_next_pc)
    );

    function automatic int idx_of(logic [PC_W-1:0] pc);
        return int'(pc) % LINES;
    endfunction

    function automatic bit exp_hit(logic [PC_W-1:0] pc, bit pt);
        int i = idx_of(pc);
        return ref_v[i] && (ref_pc[i] == pc) && (!ref_br[i] || ref_tk[i] == pt);
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, check at the next falling edge
    task automatic cycle(string req, bit fv, logic [PC_W-1:0] pc, bit pt,
                         bit flv, logic [PC_W-1:0] fpc, bit fbr, bit ftk,
                         logic [INST_W-1:0] fi0, logic [INST_W-1:0] fi1,
                         logic [PC_W-1:0] ftgt);
        bit                h;
        logic [INST_W-1:0] e0, e1;
        logic [PC_W-1:0]   en;
        int                i = idx_of(pc);
        int                k;
        h  = exp_hit(pc, pt);
        e0 = h ? ref_i0[i] : ref_mem[pc];
        e1 = h ? ref_i1[i] : ref_mem[PC_W'(pc + 1)];
        en = (h && ref_br[i] && ref_tk[i]) ? PC_W'(ref_tgt[i] + 1) : PC_W'(pc + 2);
        fetch_valid = fv; fetch_pc = pc; fetch_pred_taken = pt;
        fill_valid = flv; fill_pc = fpc; fill_has_branch = fbr; fill_taken = ftk;
        fill_inst0 = fi0; fill_inst1 = fi1; fill_target = ftgt;
        @(negedge clk);
        fetch_valid = 1'b0; fill_valid = 1'b0;
        check(req, "out_valid", 64'(out_valid), 64'(fv));
        if (fv) begin
            check(req, "out_hit", 64'(out_hit), 64'(h));
            check(req, "out_inst0", 64'(out_inst0), 64'(e0));
            check(req, "out_inst1", 64'(out_inst1), 64'(e1));
            check(req, "out_next_pc", 64'(out_next_pc), 64'(en));
        end
        if (flv) begin
            k = idx_of(fpc);
            ref_v[k] = 1'b1; ref_pc[k] = fpc; ref_br[k] = fbr; ref_tk[k] = ftk;
            ref_i0[k] = fi0; ref_i1[k] = fi1; ref_tgt[k] = ftgt;
        end
    endtask

    task automatic fetch(string req, logic [PC_W-1:0] pc, bit pt);
        cycle(req, 1'b1, pc, pt, 1'b0, '0, 1'b0, 1'b0, '0, '0, '0);
    endtask

    task automatic fill(logic [PC_W-1:0] pc, bit br, bit tk, logic [PC_W-1:0] tgt);
        logic [INST_W-1:0] a = $urandom;
        logic [INST_W-1:0] b = $urandom;
        cycle("R4", 1'b0, '0, 1'b0, 1'b1, pc, br, tk, a, b, tgt);
    endtask

    task automatic mem_write(logic [PC_W-1:0] a, logic [INST_W-1:0] d);
        mem_wr_en = 1'b1; mem_wr_addr = a; mem_wr_data = d;
        @(negedge clk);
        mem_wr_en = 1'b0;
        ref_mem[a] = d;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        for (int i = 0; i < LINES; i++) ref_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        // R1: output valid low while in reset
        check("R1", "out_valid in reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        for (int a = 0; a < DEPTH; a++) mem_write(PC_W'(a), $urandom);
        check("R1", "out_valid after reset", 64'(out_valid), 64'd0);
        // R1 / R3: nothing cached after reset
        fetch("R1", 8'd0, 1'b1);
        fetch("R3", 8'd0, 1'b0);
        fetch("R2", 8'd9, 1'b0);
        cycle("R2", 1'b0, 8'd9, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0, '0, '0);
        // R4 / R7: taken branch line at 0 with target 4
        cycle("R4", 1'b0, '0, 1'b0, 1'b1, 8'd0, 1'b1, 1'b1, ref_mem[0], ref_mem[4], 8'd4);
        fetch("R4", 8'd0, 1'b1);
        fetch("R7", 8'd0, 1'b1);
        // R5: wrong direction falls back to memory
        fetch("R5", 8'd0, 1'b0);
        // R6: branch-free line at 3
        fill(8'd3, 1'b0, 1'b1, 8'd77);
        fetch("R6", 8'd3, 1'b0);
        fetch("R6", 8'd3, 1'b1);
        // R7: not-taken branch line at 1
        fill(8'd1, 1'b1, 1'b0, 8'd50);
        fetch("R7", 8'd1, 1'b0);
        fetch("R5", 8'd1, 1'b1);
        // R8: alias with differing tag
        fetch("R8", 8'd8, 1'b1);
        // R9: replace line 0 with PC 8
        fill(8'd8, 1'b1, 1'b1, 8'd200);
        fetch("R9", 8'd0, 1'b1);
        fetch("R9", 8'd8, 1'b1);
        // R10: fill 16 while fetching 8 on the same index
        cycle("R10", 1'b1, 8'd8, 1'b1, 1'b1, 8'd16, 1'b0, 1'b0, $urandom, $urandom, 8'd0);
        fetch("R10", 8'd8, 1'b1);
        fetch("R10", 8'd16, 1'b0);
        // R11: memory updates seen on a miss, not on a hit
        mem_write(8'd40, 32'hCAFE_0040);
        fetch("R11", 8'd40, 1'b0);
        mem_write(8'd16, 32'hDEAD_0016);
        fetch("R11", 8'd16, 1'b1);
        // R3: wrap at the top of the address space
        fetch("R3", 8'd255, 1'b0);
        fetch("R3", 8'd254, 1'b1);
        // Random mix of fills and fetches over a small PC range
        for (int n = 0; n < 600; n++) begin
            bit fv  = ($urandom % 4) != 0;
            bit flv = ($urandom % 3) == 0;
            cycle("R4", fv, PC_W'($urandom % 32), 1'($urandom),
                  flv, PC_W'($urandom % 32), 1'($urandom), 1'($urandom),
                  $urandom, $urandom, PC_W'($urandom));
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule